// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the operand address for the indexed addressing forms of a small 8-bit processor whose index register is 8 bits wide and always treated as unsigned. The sequencer presents a two-bit form select, the current index value and the operand bytes that followed the opcode. One clock later the block returns a 16-bit effective address and the instruction length in bytes, so the fetch logic can step the program counter past the instruction.

There are three legal forms. The plain form uses the index register alone. The short-offset form adds one operand byte, and the carry out of the low byte is kept, so addresses up to 0x01FE are reachable. The long-offset form adds a two-byte offset and wraps within the 64 KiB space. The fourth select code is illegal and raises an error flag. The results are held in an output register that carries a valid bit, so the block fits into a multi-cycle fetch and execute sequence.

Top module: `idx_ea_gen`

## Requirements
- R1: With `mode` = 2'b00 (plain form) the result is `ea` = {8'h00, `idx`} and `len` = 1, so `ea` never exceeds 0x00FF.
- R2: With `mode` = 2'b01 (short offset) the result is `ea` = `idx` + `op_b0` as an unsigned 9-bit sum with the carry kept in bit 8, bits 15..9 zero, and `len` = 2. The largest result is 0x01FE.
- R3: With `mode` = 2'b10 (long offset) `op_b0` is the high offset byte and `op_b1` is the low offset byte. The result is `ea` = ({`op_b0`,`op_b1`} + `idx`) mod 65536 and `len` = 3.
- R4: With `mode` = 2'b11 the result is `err` = 1, `ea` = 0 and `len` = 0. For every legal mode `err` = 0.
- R5: When `in_valid` is high at a rising edge, `ea`, `len` and `err` take the result for the inputs sampled at that edge, and `out_valid` is high in the following cycle.
- R6: When `in_valid` is low at a rising edge, `out_valid` is low afterwards and `ea`, `len` and `err` keep their previous values, whatever the other inputs are.
- R7: A synchronous reset (`rst` high at a rising edge) clears `out_valid`, `ea`, `len` and `err`. Reset takes priority over `in_valid`.
- R8: Operand bytes that a form does not use have no effect: `op_b0` and `op_b1` in the plain form, and `op_b1` in the short-offset form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe for the inputs in this cycle |
| mode | input | 2 | Addressing form select: 00 plain, 01 short offset, 10 long offset, 11 illegal |
| idx | input | 8 | Unsigned index register value |
| op_b0 | input | 8 | First byte after the opcode (the offset, or the high offset byte) |
| op_b1 | input | 8 | Second byte after the opcode (the low offset byte) |
| out_valid | output | 1 | Registered result is new this cycle |
| ea | output | 16 | Registered effective address |
| len | output | 2 | Registered instruction length in bytes |
| err | output | 1 | Registered illegal-form flag |

## Verification
The hardest cases to reach are the exact carry boundaries: a short-offset sum that just crosses into bit 8, and a long-offset sum that just wraps past 0xFFFF. Each needs a specific pairing of index and offset that random values rarely produce. The stimulus therefore sweeps all 256 index values against the offsets 0x00 and 0xFF in the short form, and against 0x0000, 0x00FF and 0xFFFF in the long form. Random traffic is then added, with random junk in the unused bytes, idle cycles and a reset asserted while a request is pending.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  localparam int IX_W  = 8;
  localparam int EA_W  = 2 * IX_W;
  localparam int LEN_W = 2;

  typedef enum logic [1:0] {
    IXM_NONE  = 2'b00,
    IXM_OFF8  = 2'b01,
    IXM_OFF16 = 2'b10,
    IXM_BAD   = 2'b11
  } ixmode_e;

  // Plain form: zero-extend the index register.
  function automatic logic [EA_W-1:0] ea_plain(input logic [IX_W-1:0] ix);
    return {{(EA_W-IX_W){1'b0}}, ix};
  endfunction

  // Short-offset form: unsigned add, keeping the carry as the top bit.
  function automatic logic [IX_W:0] ea_short(input logic [IX_W-1:0] ix,
                                             input logic [IX_W-1:0] ofs);
    return {1'b0, ix} + {1'b0, ofs};
  endfunction

  // Long-offset form: the high byte comes first; the sum wraps modulo 2^EA_W.
  function automatic logic [EA_W-1:0] ea_long(input logic [IX_W-1:0] ix,
                                              input logic [IX_W-1:0] hi,
                                              input logic [IX_W-1:0] lo);
    return {hi, lo} + {{(EA_W-IX_W){1'b0}}, ix};
  endfunction

  // Instruction length in bytes; the illegal form reports zero.
  function automatic logic [LEN_W-1:0] form_len(input ixmode_e m);
    case (m)
      IXM_NONE:  return LEN_W'(1);
      IXM_OFF8:  return LEN_W'(2);
      IXM_OFF16: return LEN_W'(3);
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
  import idx_ea_pkg::*;
#(
  parameter int LEN_W_P = LEN_W
) (
  input  logic [1:0]         mode_i,
  output logic [3:0]         sel_o,
  output logic [LEN_W_P-1:0] len_o,
  output logic               bad_o
);

  ixmode_e form;
  assign form = ixmode_e'(mode_i);

  always_comb begin
    sel_o = '0;
    case (form)
      IXM_NONE:  sel_o[0] = 1'b1;
      IXM_OFF8:  sel_o[1] = 1'b1;
      IXM_OFF16: sel_o[2] = 1'b1;
      default:   sel_o[3] = 1'b1;
    endcase
  end

  assign len_o = LEN_W_P'(form_len(form));
  assign bad_o = sel_o[3];

endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter int IX_W_P = IX_W,
  parameter int EA_W_P = EA_W
) (
  input  logic [IX_W_P-1:0] ix_i,
  input  logic [IX_W_P-1:0] b0_i,
  input  logic [IX_W_P-1:0] b1_i,
  input  logic [3:0]        sel_i,
  output logic [EA_W_P-1:0] ea_o,
  output logic              carry8_o
);

  localparam int PAD_W = EA_W_P - IX_W_P - 1;

  logic [IX_W_P:0]   sum_short;
  logic [EA_W_P-1:0] sum_long;
  logic [EA_W_P-1:0] sum_plain;

  assign sum_plain = ea_plain(ix_i);
  assign sum_short = ea_short(ix_i, b0_i);
  assign sum_long  = ea_long(ix_i, b0_i, b1_i);
  assign carry8_o  = sum_short[IX_W_P];

  always_comb begin
    ea_o = '0;
    if (sel_i[0])      ea_o = sum_plain;
    else if (sel_i[1]) ea_o = {{PAD_W{1'b0}}, sum_short};
    else if (sel_i[2]) ea_o = sum_long;
  end

endmodule

// File: rtl/idx_ea_oreg.sv
module idx_ea_oreg #(
  parameter int EA_W_P  = 16,
  parameter int LEN_W_P = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [EA_W_P-1:0]  ea_i,
  input  logic [LEN_W_P-1:0] len_i,
  input  logic               err_i,
  output logic               vld_o,
  output logic [EA_W_P-1:0]  ea_o,
  output logic [LEN_W_P-1:0] len_o,
  output logic               err_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      ea_o  <= '0;
      len_o <= '0;
      err_o <= 1'b0;
    end else begin
      vld_o <= load_i;
      if (load_i) begin
        ea_o  <= ea_i;
        len_o <= len_i;
        err_o <= err_i;
      end
    end
  end

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic [IX_W-1:0]  idx,
  input  logic [IX_W-1:0]  op_b0,
  input  logic [IX_W-1:0]  op_b1,
  output logic             out_valid,
  output logic [EA_W-1:0]  ea,
  output logic [LEN_W-1:0] len,
  output logic             err
);

  // Internal events, named for the checker.
  logic [3:0]       form_sel;
  logic [LEN_W-1:0] len_next;
  logic             form_bad;
  logic [EA_W-1:0]  ea_next;
  logic             short_carry;

  idx_ea_decode #(.LEN_W_P(LEN_W)) u_decode (
    .mode_i (mode),
    .sel_o  (form_sel),
    .len_o  (len_next),
    .bad_o  (form_bad)
  );

  idx_ea_calc #(.IX_W_P(IX_W), .EA_W_P(EA_W)) u_calc (
    .ix_i     (idx),
    .b0_i     (op_b0),
    .b1_i     (op_b1),
    .sel_i    (form_sel),
    .ea_o     (ea_next),
    .carry8_o (short_carry)
  );

  idx_ea_oreg #(.EA_W_P(EA_W), .LEN_W_P(LEN_W)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .load_i (in_valid),
    .ea_i   (ea_next),
    .len_i  (len_next),
    .err_i  (form_bad),
    .vld_o  (out_valid),
    .ea_o   (ea),
    .len_o  (len),
    .err_o  (err)
  );

endmodule

// File: rtl/idx_ea_gen_chk.sv
module idx_ea_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [1:0]  mode,
  input logic [3:0]  form_sel,
  input logic        short_carry,
  input logic        out_valid,
  input logic [15:0] ea,
  input logic [1:0]  len,
  input logic        err
);

  // R1
  plain_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00) |=> (ea[15:8] == 8'h00 && len == 2'd1));

  // R2
  short_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01) |=> (ea <= 16'h01FE && len == 2'd2));

  // R2
  short_carry_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel[1] && short_carry) |=> (ea[8] == 1'b1));

  // R3
  long_len_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b10) |=> (len == 2'd3 && !err));

  // R4
  bad_form_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (ea == 16'h0000 && len == 2'd0));

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(ea) && $stable(len) && $stable(err)));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && ea == 16'h0000 && len == 2'd0 && !err));

  // R4
  select_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(form_sel) && form_sel != 4'b0000);

endmodule

bind idx_ea_gen idx_ea_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .mode        (mode),
  .form_sel    (form_sel),
  .short_carry (short_carry),
  .out_valid   (out_valid),
  .ea          (ea),
  .len         (len),
  .err         (err)
);

// File: tb/idx_ea_gen_tb.sv
module idx_ea_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  mode;
  logic [7:0]  idx, op_b0, op_b1;
  logic        out_valid;
  logic [15:0] ea;
  logic [1:0]  len;
  logic        err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ea_gen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .idx(idx),
    .op_b0(op_b0), .op_b1(op_b1), .out_valid(out_valid), .ea(ea),
    .len(len), .err(err)
  );

  // Reference model, written from the requirements.
  function automatic int exp_ea(input int m, input int x, input int b0, input int b1);
    if (m == 0) return x;
    if (m == 1) return x + b0;
    if (m == 2) return (b0 * 256 + b1 + x) % 65536;
    return 0;
  endfunction

  function automatic int exp_len(input int m);
    return (m == 3) ? 0 : m + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (mode=%0d idx=%02h b0=%02h b1=%02h)",
               req, act, exp, mode, idx, op_b0, op_b1);
    end
  endtask

  // Called at a falling edge; drives a request and checks one cycle later.
  task automatic request(input string req, input int m, input int x, input int b0, input int b1);
    in_valid = 1'b1;
    mode = 2'(m); idx = 8'(x); op_b0 = 8'(b0); op_b1 = 8'(b1);
    @(negedge clk);
    check({req, " out_valid"}, int'(out_valid), 1);
    check({req, " ea"}, int'(ea), exp_ea(m, x, b0, b1));
    check({req, " len"}, int'(len), exp_len(m));
    check({req, " err"}, int'(err), (m == 3) ? 1 : 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int unsigned seed_dummy;
    logic [15:0] held_ea;
    logic [1:0]  held_len;
    seed_dummy = $urandom(32'h5EED_0C1D);
    rst = 1'b1; in_valid = 1'b0; mode = '0; idx = '0; op_b0 = '0; op_b1 = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 reset out_valid", int'(out_valid), 0);
    check("R7 reset ea", int'(ea), 0);
    check("R7 reset len", int'(len), 0);
    check("R7 reset err", int'(err), 0);
    rst = 1'b0;
    @(negedge clk);

    // Directed sweeps over every index value.
    for (int x = 0; x < 256; x++) begin
      request("R1", 0, x, 8'hA5, 8'h5A);
      request("R2", 1, x, 8'h00, 8'h33);
      request("R2", 1, x, 8'hFF, 8'hC3);
      request("R3", 2, x, 8'h00, 8'h00);
      request("R3", 2, x, 8'h00, 8'hFF);
      request("R3", 2, x, 8'hFF, 8'hFF);
    end
    // Corner points
    request("R2 max", 1, 8'hFF, 8'hFF, 0);
    check("R2 max ea", int'(ea), 16'h01FE);
    request("R3 wrap", 2, 8'h01, 8'hFF, 8'hFF);
    check("R3 wrap ea", int'(ea), 16'h0000);
    request("R4", 3, 8'h7E, 8'h12, 8'h34);

    // R8: unused bytes must not change the result.
    for (int k = 0; k < 64; k++) begin
      int x;
      x = $urandom_range(0, 255);
      request("R8 plain", 0, x, $urandom_range(0, 255), $urandom_range(0, 255));
      request("R8 short", 1, x, 8'h40, $urandom_range(0, 255));
    end

    // Random traffic with idle cycles (R5, R6).
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        held_ea = ea; held_len = len;
        in_valid = 1'b0;
        mode = 2'($urandom); idx = 8'($urandom); op_b0 = 8'($urandom); op_b1 = 8'($urandom);
        @(negedge clk);
        check("R6 idle out_valid", int'(out_valid), 0);
        check("R6 idle ea", int'(ea), int'(held_ea));
        check("R6 idle len", int'(len), int'(held_len));
      end else begin
        request("R5 random", $urandom_range(0, 3), $urandom_range(0, 255),
                $urandom_range(0, 255), $urandom_range(0, 255));
      end
    end

    // R7: reset wins over a pending request.
    in_valid = 1'b1; mode = 2'b10; idx = 8'h11; op_b0 = 8'h22; op_b1 = 8'h33;
    rst = 1'b1;
    @(negedge clk);
    check("R7 priority out_valid", int'(out_valid), 0);
    check("R7 priority ea", int'(ea), 0);
    check("R7 priority len", int'(len), 0);
    rst = 1'b0;
    request("R5 after reset", 2, 8'h11, 8'h22, 8'h33);

    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule